// File: doc/BRIEF.md
# Per-Pin GPIO Interrupt Detector

This block watches one bank of general-purpose input pins, arranged as up to four ports of eight pins, and turns pin activity into a single bank interrupt line. Each pin has its own trigger setting. It can fire on a rising edge, a falling edge or both edges, or it can follow a high or low level. Pin inputs pass through a synchroniser before detection. A detected condition is recorded in a per-port status byte. A per-port enable byte decides which recorded conditions reach the interrupt line.

Software reaches the block through a simple word-wide write/read port. Each port's status, enable and trigger registers can be written whole at their plain offsets. They can also be updated bit-selectively through an alias window, where the upper byte of the write data selects which bits of the lower byte take effect. A separate write-one-to-clear register per port acknowledges recorded edges. Read data is registered, so it appears one cycle after the address.

Top module: `gpio_irq_bank`

## Requirements
- R1: After a synchronous reset every enable and trigger register reads zero and `irq` is low; `irq` stays low until some enable bit is set.
- R2: A port's 24-bit trigger register holds, for pin n, a high/rising bit at n, an edge-mode bit at 8+n and a both-edges bit at 16+n. Per pin, 0x101 is rising, 0x100 is falling, 0x10100 is both edges, 0x1 is level high and 0 is level low.
- R3: In rising-edge mode a 0-to-1 pin change sets the pin's status bit on the third clock edge after the pin is sampled (two synchroniser stages plus detection). The bit stays set after the pin returns low.
- R4: In falling-edge mode only a 1-to-0 pin change sets the status bit; a rising change leaves it unchanged.
- R5: In both-edges mode either pin transition sets the status bit.
- R6: In level mode the status bit is a registered copy of "pin at its active level". Clear writes and masked status writes have no effect on it.
- R7: `irq` is a register loaded each cycle with the OR over all ports of status AND enable, so it follows the status by one cycle.
- R8: Writing to the clear register (offset 0x70 + 4*port) clears, in edge mode, each status bit whose data bit is 1; a 0 bit has no effect.
- R9: When an edge is detected in the same cycle as a clear of that bit, the bit stays set.
- R10: Writes at the alias window (base UPPER_OFS) to 0x40 + 4*port (status) and 0x50 + 4*port (enable) update only the bits whose mask bit in data[15:8] is 1, loading them from data[7:0].
- R11: Alias writes update one byte lane of the trigger register. Offset 0x60 + 4*port reaches lane 0 (bits 7:0), 0x80 + 4*port reaches lane 1 (bits 15:8) and 0x90 + 4*port reaches lane 2 (bits 23:16). Each uses the data[15:8] mask.
- R12: A read of a plain offset returns, one cycle later, the port's status (0x40), enable (0x50) or trigger (0x60), zero-extended. Reads of the clear register and of the alias window return 0, and a plain write to 0x40 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | NPORTS*PINS | Asynchronous pin levels, pin p*PINS+n is pin n of port p |
| bus_wr | input | 1 | Write strobe for the current address |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data for the previous cycle's address |
| irq | output | 1 | Registered bank interrupt |

## Verification
Two events can meet on the same status bit in one cycle: an edge detected from the synchronised pin, and a software clear (or a masked status write) of that bit. The bench provokes the collision by counting edges. It raises a pin and then issues the clear so that it lands on exactly the third edge after the pin is sampled, the cycle in which detection fires. The bit must read back as set. A behavioural model is compared with `irq` and `bus_rdata` on every cycle, so the same collision is judged again wherever it arises incidentally during level/edge mode changes.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  // Register group selected by an access
  typedef enum logic [2:0] {
    RG_NONE = 3'd0,
    RG_STAT = 3'd1,
    RG_ENAB = 3'd2,
    RG_TYPE = 3'd3,
    RG_CLR  = 3'd4
  } reg_grp_e;

  // Group base offsets inside a window (plain or alias)
  localparam logic [7:0] OFS_STAT    = 8'h40;
  localparam logic [7:0] OFS_ENAB    = 8'h50;
  localparam logic [7:0] OFS_TYPE    = 8'h60;
  localparam logic [7:0] OFS_CLR     = 8'h70;
  localparam logic [7:0] OFS_TYPE_L1 = 8'h80;
  localparam logic [7:0] OFS_TYPE_L2 = 8'h90;

  // Decoded access
  typedef struct packed {
    reg_grp_e   grp;
    logic       masked;
    logic [1:0] lane;
    logic [1:0] port;
  } acc_t;

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_prev
);

  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain  <= '0;
      q_prev <= '0;
    end else begin
      chain[0] <= d;
      for (int k = 1; k < STAGES; k++) begin
        chain[k] <= chain[k-1];
      end
      q_prev <= chain[STAGES-1];
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/gpio_irq_decode.sv
module gpio_irq_decode
  import gpio_irq_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NPORTS    = 4,
  parameter int UPPER_OFS = 256
) (
  input  logic [ADDR_W-1:0] addr,
  output acc_t              acc
);

  localparam logic [ADDR_W-1:0] UPPER_A = ADDR_W'(UPPER_OFS);
  localparam logic [2:0]        NP3     = 3'(NPORTS);

  logic              in_alias;
  logic [ADDR_W-1:0] loc;
  logic [7:0]        grp_ofs;
  logic              well_formed;

  always_comb begin
    in_alias    = (addr >= UPPER_A);
    loc         = in_alias ? (addr - UPPER_A) : addr;
    grp_ofs     = {loc[7:4], 4'h0};
    well_formed = (loc[ADDR_W-1:8] == '0) && (loc[1:0] == 2'b00) &&
                  ({1'b0, loc[3:2]} < NP3);

    acc        = '0;
    acc.masked = in_alias;
    acc.port   = loc[3:2];
    if (well_formed) begin
      unique case (grp_ofs)
        OFS_STAT:    acc.grp = RG_STAT;
        OFS_ENAB:    acc.grp = RG_ENAB;
        OFS_TYPE:    acc.grp = RG_TYPE;
        OFS_CLR:     acc.grp = in_alias ? RG_NONE : RG_CLR;
        OFS_TYPE_L1: begin
          acc.grp  = in_alias ? RG_TYPE : RG_NONE;
          acc.lane = 2'd1;
        end
        OFS_TYPE_L2: begin
          acc.grp  = in_alias ? RG_TYPE : RG_NONE;
          acc.lane = 2'd2;
        end
        default:     acc.grp = RG_NONE;
      endcase
    end
  end

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port #(
  parameter int PINS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PINS-1:0]   s,
  input  logic [PINS-1:0]   s_prev,
  input  logic [PINS-1:0]   en_we,
  input  logic [PINS-1:0]   en_wv,
  input  logic [3*PINS-1:0] ty_we,
  input  logic [3*PINS-1:0] ty_wv,
  input  logic [PINS-1:0]   st_we,
  input  logic [PINS-1:0]   st_wv,
  input  logic [PINS-1:0]   clr,
  output logic [PINS-1:0]   status,
  output logic [PINS-1:0]   enable,
  output logic [3*PINS-1:0] ttype,
  output logic [PINS-1:0]   edge_md,
  output logic [PINS-1:0]   evt,
  output logic [PINS-1:0]   lvl_act
);

  logic [PINS-1:0] hi_sel, both_sel, rise, fall, kept, st_next;

  always_comb begin
    hi_sel   = ttype[PINS-1:0];
    edge_md  = ttype[2*PINS-1:PINS];
    both_sel = ttype[3*PINS-1:2*PINS];
    rise     = s & ~s_prev;
    fall     = ~s & s_prev;
    evt      = edge_md & ((both_sel & (rise | fall)) |
                          (~both_sel & hi_sel & rise) |
                          (~both_sel & ~hi_sel & fall));
    lvl_act  = ~edge_md & ~(hi_sel ^ s);
    // software view of the bit: masked write, then clear; a new edge wins
    kept     = ((status & ~st_we) | (st_wv & st_we)) & ~clr;
    st_next  = (edge_md & (evt | kept)) | lvl_act;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      enable <= '0;
      ttype  <= '0;
    end else begin
      status <= st_next;
      enable <= (enable & ~en_we) | (en_wv & en_we);
      ttype  <= (ttype & ~ty_we) | (ty_wv & ty_we);
    end
  end

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int NPORTS      = 4,
  parameter int PINS        = 8,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 32,
  parameter int UPPER_OFS   = 256
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NPORTS*PINS-1:0] pin_in,
  input  logic                   bus_wr,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [DATA_W-1:0]      bus_wdata,
  output logic [DATA_W-1:0]      bus_rdata,
  output logic                   irq
);

  localparam int NPINS  = NPORTS * PINS;
  localparam int TYPE_W = 3 * PINS;

  logic [NPINS-1:0] s_all, sprev_all;
  acc_t             acc;

  logic [NPORTS-1:0][PINS-1:0]   stat_a, en_a;
  logic [NPORTS-1:0][TYPE_W-1:0] ty_a;

  logic [NPINS-1:0] status_flat, enable_flat, edge_flat, evt_flat;
  logic [NPINS-1:0] lvl_flat, clr_flat, swr_flat;

  logic [PINS-1:0] wd_val, wd_msk;
  logic            unused_wdata;

  assign wd_val       = bus_wdata[PINS-1:0];
  assign wd_msk       = bus_wdata[2*PINS-1:PINS];
  assign unused_wdata = ^bus_wdata[DATA_W-1:TYPE_W];

  gpio_irq_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .d      (pin_in),
    .q      (s_all),
    .q_prev (sprev_all)
  );

  gpio_irq_decode #(.ADDR_W(ADDR_W), .NPORTS(NPORTS), .UPPER_OFS(UPPER_OFS)) u_dec (
    .addr (bus_addr),
    .acc  (acc)
  );

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    logic              sel;
    logic [PINS-1:0]   en_we, en_wv, st_we, st_wv, clr;
    logic [TYPE_W-1:0] ty_we, ty_wv;
    logic [PINS-1:0]   edm, ev, la;

    assign sel = bus_wr && (acc.grp != RG_NONE) && (acc.port == 2'(p));

    always_comb begin
      en_we = '0;
      en_wv = '0;
      ty_we = '0;
      ty_wv = '0;
      st_we = '0;
      st_wv = '0;
      clr   = '0;
      if (sel) begin
        unique case (acc.grp)
          RG_ENAB: begin
            en_we = acc.masked ? wd_msk : '1;
            en_wv = wd_val;
          end
          RG_TYPE: begin
            if (!acc.masked) begin
              ty_we = '1;
              ty_wv = bus_wdata[TYPE_W-1:0];
            end else begin
              unique case (acc.lane)
                2'd1: begin
                  ty_we[2*PINS-1:PINS] = wd_msk;
                  ty_wv[2*PINS-1:PINS] = wd_val;
                end
                2'd2: begin
                  ty_we[3*PINS-1:2*PINS] = wd_msk;
                  ty_wv[3*PINS-1:2*PINS] = wd_val;
                end
                default: begin
                  ty_we[PINS-1:0] = wd_msk;
                  ty_wv[PINS-1:0] = wd_val;
                end
              endcase
            end
          end
          RG_STAT: begin
            if (acc.masked) begin
              st_we = wd_msk;
              st_wv = wd_val;
            end
          end
          RG_CLR:  clr = wd_val;
          default: ;
        endcase
      end
    end

    gpio_irq_port #(.PINS(PINS)) u_port (
      .clk     (clk),
      .rst     (rst),
      .s       (s_all[p*PINS +: PINS]),
      .s_prev  (sprev_all[p*PINS +: PINS]),
      .en_we   (en_we),
      .en_wv   (en_wv),
      .ty_we   (ty_we),
      .ty_wv   (ty_wv),
      .st_we   (st_we),
      .st_wv   (st_wv),
      .clr     (clr),
      .status  (stat_a[p]),
      .enable  (en_a[p]),
      .ttype   (ty_a[p]),
      .edge_md (edm),
      .evt     (ev),
      .lvl_act (la)
    );

    assign status_flat[p*PINS +: PINS] = stat_a[p];
    assign enable_flat[p*PINS +: PINS] = en_a[p];
    assign edge_flat[p*PINS +: PINS]   = edm;
    assign evt_flat[p*PINS +: PINS]    = ev;
    assign lvl_flat[p*PINS +: PINS]    = la;
    assign clr_flat[p*PINS +: PINS]    = clr;
    assign swr_flat[p*PINS +: PINS]    = st_we;
  end

  logic [DATA_W-1:0] rd_val;

  always_comb begin
    rd_val = '0;
    if (!acc.masked) begin
      unique case (acc.grp)
        RG_STAT: rd_val = DATA_W'(stat_a[acc.port]);
        RG_ENAB: rd_val = DATA_W'(en_a[acc.port]);
        RG_TYPE: rd_val = DATA_W'(ty_a[acc.port]);
        default: rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq       <= 1'b0;
      bus_rdata <= '0;
    end else begin
      irq       <= |(status_flat & enable_flat);
      bus_rdata <= rd_val;
    end
  end

endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              irq,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [NPINS-1:0]  status_flat,
  input logic [NPINS-1:0]  enable_flat,
  input logic [NPINS-1:0]  edge_flat,
  input logic [NPINS-1:0]  evt_flat,
  input logic [NPINS-1:0]  lvl_flat,
  input logic [NPINS-1:0]  clr_flat,
  input logic [NPINS-1:0]  swr_flat
);

  localparam logic [ADDR_W-1:0] CLR0_A = ADDR_W'('h70);

  // R7: the line can only be high if some pin was enabled the cycle before
  p_irq_needs_enable_r7: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(|enable_flat));

  // R12: clear register reads as zero
  p_clear_reads_zero_r12: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == CLR0_A) |=> (bus_rdata == '0));

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    // R9: a detected edge is never lost, whatever software writes
    p_edge_sets_r9: assert property (@(posedge clk) disable iff (rst)
      evt_flat[i] |=> status_flat[i]);

    // R8: a clear with no competing edge or masked write drops the bit
    p_clear_drops_r8: assert property (@(posedge clk) disable iff (rst)
      (clr_flat[i] && edge_flat[i] && !evt_flat[i] && !swr_flat[i]) |=> !status_flat[i]);

    // R6: in level mode the bit follows the active level one cycle later
    p_level_follows_r6: assert property (@(posedge clk) disable iff (rst)
      !edge_flat[i] |=> (status_flat[i] == $past(lvl_flat[i])));
  end

endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(
  .NPINS  (NPINS),
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .irq         (irq),
  .bus_addr    (bus_addr),
  .bus_rdata   (bus_rdata),
  .status_flat (status_flat),
  .enable_flat (enable_flat),
  .edge_flat   (edge_flat),
  .evt_flat    (evt_flat),
  .lvl_flat    (lvl_flat),
  .clr_flat    (clr_flat),
  .swr_flat    (swr_flat)
);

// File: tb/gpio_irq_bank_test.sv
module gpio_irq_bank_test;

  localparam int NP = 4;
  localparam int PN = 8;
  localparam int SY = 2;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam int UP = 256;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [31:0]   pin_in = '0;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          irq;

  always #5 clk = ~clk;

  gpio_irq_bank #(
    .NPORTS(NP), .PINS(PN), .SYNC_STAGES(SY),
    .ADDR_W(AW), .DATA_W(DW), .UPPER_OFS(UP)
  ) uut (
    .clk       (clk),
    .rst       (rst),
    .pin_in    (pin_in),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  int n_chk  = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [7:0]  m_st [NP];
  logic [7:0]  m_en [NP];
  logic [23:0] m_ty [NP];
  logic        m_irq = 1'b0;
  logic [31:0] m_rd  = '0;
  logic [31:0] hist [$];

  initial begin
    for (int p = 0; p < NP; p++) begin
      m_st[p] = '0; m_en[p] = '0; m_ty[p] = '0;
    end
  end

  always @(posedge clk) begin : model
    logic [31:0] cur, old, rdv;
    logic [7:0]  nst [NP];
    logic        any, mk, valid, trig, keep, h, e, b, c, o;
    int          a, off, prt, base;
    if (rst) begin
      for (int p = 0; p < NP; p++) begin
        m_st[p] = '0; m_en[p] = '0; m_ty[p] = '0;
      end
      m_irq = 1'b0;
      m_rd  = '0;
      hist  = {};
      for (int k = 0; k <= SY; k++) hist.push_back('0);
    end else begin
      cur = hist[SY-1];
      old = hist[SY];
      any = 1'b0;
      for (int p = 0; p < NP; p++) any = any | (|(m_st[p] & m_en[p]));
      a     = int'(bus_addr);
      mk    = (a >= UP);
      off   = mk ? a - UP : a;
      prt   = (off >> 2) & 3;
      base  = off & 'hF0;
      valid = (off < 256) && ((off % 4) == 0) && (prt < NP);
      rdv   = '0;
      if (valid && !mk) begin
        if (base == 'h40) rdv = {24'h0, m_st[prt]};
        if (base == 'h50) rdv = {24'h0, m_en[prt]};
        if (base == 'h60) rdv = {8'h0, m_ty[prt]};
      end
      for (int p = 0; p < NP; p++) begin
        for (int n = 0; n < PN; n++) begin
          h = m_ty[p][n]; e = m_ty[p][8+n]; b = m_ty[p][16+n];
          c = cur[p*PN+n]; o = old[p*PN+n];
          if (!e) begin
            nst[p][n] = h ? c : !c;
          end else begin
            trig = b ? (c != o) : (h ? (c && !o) : (!c && o));
            keep = m_st[p][n];
            if (bus_wr && valid && mk && base == 'h40 && prt == p && bus_wdata[8+n]) keep = bus_wdata[n];
            if (bus_wr && valid && !mk && base == 'h70 && prt == p && bus_wdata[n]) keep = 1'b0;
            nst[p][n] = trig | keep;
          end
        end
      end
      if (bus_wr && valid) begin
        if (base == 'h50) begin
          if (mk) begin
            for (int n = 0; n < PN; n++) if (bus_wdata[8+n]) m_en[prt][n] = bus_wdata[n];
          end else m_en[prt] = bus_wdata[7:0];
        end
        if (base == 'h60) begin
          if (mk) begin
            for (int n = 0; n < PN; n++) if (bus_wdata[8+n]) m_ty[prt][n] = bus_wdata[n];
          end else m_ty[prt] = bus_wdata[23:0];
        end
        if (mk && base == 'h80)
          for (int n = 0; n < PN; n++) if (bus_wdata[8+n]) m_ty[prt][8+n] = bus_wdata[n];
        if (mk && base == 'h90)
          for (int n = 0; n < PN; n++) if (bus_wdata[8+n]) m_ty[prt][16+n] = bus_wdata[n];
      end
      for (int p = 0; p < NP; p++) m_st[p] = nst[p];
      m_irq = any;
      m_rd  = rdv;
      hist.push_front(pin_in);
      void'(hist.pop_back());
    end
  end

  // every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    chk(irq === m_irq, "R7 irq vs model", {31'h0, irq}, {31'h0, m_irq});
    chk(bus_rdata === m_rd, "R12 rdata vs model", bus_rdata, m_rd);
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_addr = AW'(a);
    @(negedge clk);
    chk(bus_rdata === exp, tag, bus_rdata, exp);
  endtask

  task automatic setpin(input int i, input logic v);
    @(negedge clk);
    pin_in[i] = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    @(negedge clk);
    chk(irq === exp, tag, {31'h0, irq}, {31'h0, exp});
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk_irq(1'b0, "R1 irq low after reset");
    rd('h50, 32'h0, "R1 enable p0 reset");
    rd('h60, 32'h0, "R1 type p0 reset");
    rd('h40, 32'h0000_00FF, "R6 level-low status with pins low");

    // port 0 pin 1 rising edge
    wr('h60, 32'h0000_0202);
    rd('h60, 32'h0000_0202, "R2 type layout readback");
    wr('h50, 32'h02);
    wr('h70, 32'h02);
    rd('h40, 32'h0000_00FD, "R8 clear drops edge bit, level bits stay");
    chk_irq(1'b0, "R7 irq low with pending cleared");
    setpin(1, 1'b1);
    rd('h40, 32'h0000_00FF, "R3 rising edge sets status");
    chk_irq(1'b1, "R7 irq from enabled status");
    setpin(1, 1'b0);
    rd('h40, 32'h0000_00FF, "R3 status sticky after pin falls");
    wr('h70, 32'h02);
    rd('h40, 32'h0000_00FD, "R8 clear");

    // port 0 pin 2 falling via alias lane 1
    wr(UP + 'h80, 32'h0404);
    rd('h60, 32'h0000_0602, "R11 lane1 alias write");
    wr('h70, 32'h04);
    rd('h40, 32'h0000_00F9, "R8 clear pin2");
    setpin(2, 1'b1);
    rd('h40, 32'h0000_00F9, "R4 rising ignored in falling mode");
    setpin(2, 1'b0);
    rd('h40, 32'h0000_00FD, "R4 falling edge sets status");

    // port 1 pin 3 both edges
    wr('h64, 32'h0008_0800);
    wr('h74, 32'h08);
    rd('h44, 32'h0000_00F7, "R8 clear port1");
    setpin(11, 1'b1);
    rd('h44, 32'h0000_00FF, "R5 rise in both mode");
    wr('h74, 32'h08);
    rd('h44, 32'h0000_00F7, "R8 clear port1 again");
    setpin(11, 1'b0);
    rd('h44, 32'h0000_00FF, "R5 fall in both mode");

    // port 2 pin 4 level high
    wr('h68, 32'h0000_0010);
    rd('h48, 32'h0000_00EF, "R6 level high, pin low");
    setpin(20, 1'b1);
    rd('h48, 32'h0000_00FF, "R6 level high, pin high");
    wr('h78, 32'h10);
    rd('h48, 32'h0000_00FF, "R6 clear has no effect in level mode");
    setpin(20, 1'b0);
    rd('h48, 32'h0000_00EF, "R6 level released");

    // port 3 alias lanes 2 and 0
    wr(UP + 'h9C, 32'h0101);
    rd('h6C, 32'h0001_0000, "R11 lane2 alias write");
    wr(UP + 'h6C, 32'h0301);
    rd('h6C, 32'h0001_0001, "R11 lane0 alias write with mask");
    rd('h4C, 32'h0000_00FE, "R6 pin switched to level high");

    // edge and clear in the same cycle on port 0 pin 1
    @(negedge clk); pin_in[1] = 1'b1;
    @(negedge clk);
    @(negedge clk); bus_wr = 1'b1; bus_addr = AW'('h70); bus_wdata = 32'h02;
    @(negedge clk); bus_wr = 1'b0;
    rd('h40, 32'h0000_00FF, "R9 edge wins over same-cycle clear");
    wr('h70, 32'h06);
    rd('h40, 32'h0000_00F9, "R8 later clear takes effect");

    // masked enable and status writes
    wr(UP + 'h50, 32'h0404);
    rd('h50, 32'h0000_0006, "R10 masked enable write");
    wr(UP + 'h44, 32'h0800);
    rd('h44, 32'h0000_00F7, "R10 masked status clear");
    wr(UP + 'h44, 32'h0808);
    rd('h44, 32'h0000_00FF, "R10 masked status set");
    wr('h44, 32'h0);
    rd('h44, 32'h0000_00FF, "R12 plain status write ignored");

    // interrupt gating
    chk_irq(1'b0, "R7 no enabled status");
    wr(UP + 'h40, 32'h0202);
    chk_irq(1'b1, "R7 masked status set raises irq");
    wr('h50, 32'h0);
    chk_irq(1'b0, "R7 enable removed");
    wr('h58, 32'h10);
    chk_irq(1'b0, "R7 enabled level inactive");
    setpin(20, 1'b1);
    chk_irq(1'b1, "R7 enabled level active");

    // reads returning zero
    rd('h70, 32'h0, "R12 clear reads zero");
    rd(UP + 'h50, 32'h0, "R12 alias reads zero");

    // reset mid-run
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk_irq(1'b0, "R1 irq low after second reset");
    rd('h58, 32'h0, "R1 enable p2 cleared");
    rd('h68, 32'h0, "R1 type p2 cleared");

    repeat (4) @(negedge clk);
    summary();
    $finish;
  end

endmodule